// File: doc/BRIEF.md
# Trap Entry and Status Unit

This block keeps the mode and trap bookkeeping of a small processor core: an 8-bit status register, an exception base register, a saved exception PC and a captured faulting address. When a trap is requested and traps are enabled, it redirects the program counter in a single clock. The new PC is the exception base plus the trap number times 128. In that same clock it saves the trapping PC and the faulting address, switches the core to supervisor mode and records the old mode.

A trap that arrives while traps are disabled, or that carries a trap number outside the supported range, does not vector. Instead it sends the core into a halting error mode. That mode is sticky until reset. Software can load the status and base registers through a simple write port, and a trap in the same cycle wins over that write. The block also reports the effective integer width. The width is 64 bits when the current mode has its 64-bit enable set and the configuration flag permits 64-bit operation. Otherwise it is 32 bits.

Top module: `trap_status_unit`

## Requirements
- R1: After reset the redirect PC, exception base, exception PC and bad-address registers read 0, the halt flag is low, and status reads 0x12 (supervisor and kernel-64 set) when `cfg_has64` is high, or 0x02 when it is low.
- R2: A taken trap (status bit0 trap-enable set, number below NUM_TRAPS, not halted) makes `redir_pc` equal to `exc_base + trap_num*128` on the next clock, with `redir_vld` high for exactly that one cycle.
- R3: A taken trap loads `exc_pc` with the `cur_pc` presented with the request.
- R4: A taken trap clears bit0 (trap-enable), sets bit1 (supervisor), copies the old bit1 into bit2 (previous-supervisor), and keeps bits 3 and 4 unchanged.
- R5: A taken trap loads `bad_addr` with `fault_addr`.
- R6: A trap request while bit0 is clear raises `halt` on the next clock and changes no other register.
- R7: A trap request whose number is NUM_TRAPS or more raises `halt` and changes no other register.
- R8: Once raised, `halt` stays high until reset, and later trap requests and software writes have no effect.
- R9: Status bits 7:5 always read 0, and bits 3 (user-64) and 4 (kernel-64) read 0 whenever `cfg_has64` is low.
- R10: `xlen_is64` equals bit4 when bit1 is set, and equals bit3 otherwise.
- R11: A trap request, whether taken or erroneous, blocks a software write to status or base in the same cycle.
- R12: A software base write (`sw_we_base`) loads `exc_base` with `sw_wdata` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_has64 | input | 1 | 64-bit operation permitted |
| trap_req | input | 1 | Trap request |
| trap_num | input | TRAP_W | Trap number |
| cur_pc | input | XLEN | PC of the trapping instruction |
| fault_addr | input | XLEN | Faulting address from the memory unit |
| sw_we_stat | input | 1 | Software write strobe for status |
| sw_we_base | input | 1 | Software write strobe for exception base |
| sw_wdata | input | XLEN | Software write data |
| redir_pc | output | XLEN | Redirected PC after a taken trap |
| redir_vld | output | 1 | One-cycle pulse marking a redirect |
| status | output | 8 | Effective status register |
| exc_base | output | XLEN | Exception base register |
| exc_pc | output | XLEN | Saved exception PC |
| bad_addr | output | XLEN | Captured faulting address |
| xlen_is64 | output | 1 | Effective integer width is 64 |
| halt | output | 1 | Error-mode halt flag |

## Verification
The bench builds the unit with XLEN 64, a 5-bit trap number and NUM_TRAPS set to 24. With those values, trap numbers 24 to 31 fit the field but lie outside the supported range, so the out-of-range error path can be reached. The default count of 32 would hide that path. Both settings of `cfg_has64` are run, which exposes the masking of the 64-bit enable bits and the width choice in each mode.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int ST_W   = 8;
  localparam int ST_ET  = 0;
  localparam int ST_S   = 1;
  localparam int ST_PS  = 2;
  localparam int ST_U64 = 3;
  localparam int ST_K64 = 4;
  localparam logic [ST_W-1:0] ST_RESET = 8'h12;

  // bits that may read non-zero for the given configuration
  function automatic logic [ST_W-1:0] st_mask(input logic has64);
    return has64 ? 8'h1F : 8'h07;
  endfunction
endpackage

// File: rtl/tsu_rst_sync.sv
module tsu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl #(
  parameter int TRAP_W    = 5,
  parameter int NUM_TRAPS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_req,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              trap_en,
  input  logic              sw_we_stat,
  input  logic              sw_we_base,
  output logic              take,
  output logic              stat_we,
  output logic              base_we,
  output logic              halt
);
  logic num_ok, err, halt_q, halt_d;

  generate
    if (NUM_TRAPS >= (1 << TRAP_W)) begin : g_full
      assign num_ok = 1'b1;
    end else begin : g_part
      assign num_ok = (int'(trap_num) < NUM_TRAPS);
    end
  endgenerate

  always_comb begin
    take    = trap_req & ~halt_q & trap_en & num_ok;
    err     = trap_req & ~halt_q & ~(trap_en & num_ok);
    halt_d  = halt_q | err;
    stat_we = sw_we_stat & ~trap_req & ~halt_q;
    base_we = sw_we_base & ~trap_req & ~halt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assign halt = halt_q;

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
  p_err_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_en |=> halt);
  p_badnum_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && (int'(trap_num) >= NUM_TRAPS) |=> halt);
  p_no_write_on_trap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !stat_we && !base_we);
endmodule

// File: rtl/tsu_status.sv
module tsu_status
  import tsu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_has64,
  input  logic            take,
  input  logic            stat_we,
  input  logic [ST_W-1:0] wdata,
  output logic [ST_W-1:0] stat_o,
  output logic            is64
);
  logic [ST_W-1:0] stat_q, stat_d;
  logic            stat_en;

  assign stat_o = stat_q & st_mask(cfg_has64);

  always_comb begin
    stat_en = take | stat_we;
    stat_d  = stat_q;
    if (take) begin
      stat_d        = stat_o;
      stat_d[ST_ET] = 1'b0;
      stat_d[ST_PS] = stat_o[ST_S];
      stat_d[ST_S]  = 1'b1;
    end else if (stat_we) begin
      stat_d = wdata & st_mask(1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= ST_RESET;
    else if (stat_en) stat_q <= stat_d;
  end

  assign is64 = stat_o[ST_S] ? stat_o[ST_K64] : stat_o[ST_U64];

  p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[7:5] == 3'b000);
  p_no64_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_has64 |-> stat_o[ST_K64:ST_U64] == 2'b00);
  p_trap_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> stat_o[ST_S] && !stat_o[ST_ET] && (stat_o[ST_PS] == $past(stat_o[ST_S])));
endmodule

// File: rtl/tsu_vector.sv
module tsu_vector #(
  parameter int XLEN      = 64,
  parameter int TRAP_W    = 5,
  parameter int VEC_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              base_we,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic [XLEN-1:0]   wdata,
  output logic [XLEN-1:0]   redir_pc,
  output logic              redir_vld,
  output logic [XLEN-1:0]   exc_base,
  output logic [XLEN-1:0]   exc_pc,
  output logic [XLEN-1:0]   bad_addr
);
  localparam int OFF_W = TRAP_W + VEC_SHIFT;

  logic [XLEN-1:0] vec_off, pc_d, base_d;
  logic [XLEN-1:0] pc_q, base_q, epc_q, bad_q;
  logic            vld_q;

  always_comb begin
    vec_off = {{(XLEN-OFF_W){1'b0}}, trap_num, {VEC_SHIFT{1'b0}}};
    pc_d    = base_q + vec_off;
    base_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      epc_q <= '0;
      bad_q <= '0;
    end else if (take) begin
      pc_q  <= pc_d;
      epc_q <= cur_pc;
      bad_q <= fault_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= take;
  end

  assign redir_pc  = pc_q;
  assign redir_vld = vld_q;
  assign exc_base  = base_q;
  assign exc_pc    = epc_q;
  assign bad_addr  = bad_q;

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> redir_vld);
  p_epc_saved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> exc_pc == $past(cur_pc));
  p_bad_saved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> bad_addr == $past(fault_addr));
  p_base_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> exc_base == $past(exc_base));
endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import tsu_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int TRAP_W    = 5,
  parameter int NUM_TRAPS = 32,
  parameter int VEC_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_has64,
  input  logic              trap_req,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic              sw_we_stat,
  input  logic              sw_we_base,
  input  logic [XLEN-1:0]   sw_wdata,
  output logic [XLEN-1:0]   redir_pc,
  output logic              redir_vld,
  output logic [ST_W-1:0]   status,
  output logic [XLEN-1:0]   exc_base,
  output logic [XLEN-1:0]   exc_pc,
  output logic [XLEN-1:0]   bad_addr,
  output logic              xlen_is64,
  output logic              halt
);
  logic rst_i_n, take, stat_we, base_we;

  tsu_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  tsu_ctrl #(.TRAP_W(TRAP_W), .NUM_TRAPS(NUM_TRAPS)) i_ctrl (
    .clk(clk), .rst_n(rst_i_n), .trap_req(trap_req), .trap_num(trap_num),
    .trap_en(status[ST_ET]), .sw_we_stat(sw_we_stat), .sw_we_base(sw_we_base),
    .take(take), .stat_we(stat_we), .base_we(base_we), .halt(halt)
  );

  tsu_status i_stat (
    .clk(clk), .rst_n(rst_i_n), .cfg_has64(cfg_has64), .take(take),
    .stat_we(stat_we), .wdata(sw_wdata[ST_W-1:0]), .stat_o(status),
    .is64(xlen_is64)
  );

  tsu_vector #(.XLEN(XLEN), .TRAP_W(TRAP_W), .VEC_SHIFT(VEC_SHIFT)) i_vec (
    .clk(clk), .rst_n(rst_i_n), .take(take), .base_we(base_we),
    .trap_num(trap_num), .cur_pc(cur_pc), .fault_addr(fault_addr),
    .wdata(sw_wdata), .redir_pc(redir_pc), .redir_vld(redir_vld),
    .exc_base(exc_base), .exc_pc(exc_pc), .bad_addr(bad_addr)
  );

  // trap-enable is cleared by every redirect, so redirects never come back to back
  p_vld_single_r2: assert property (@(posedge clk) disable iff (!rst_i_n)
    redir_vld |=> !redir_vld);
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_i_n)
    halt |=> !redir_vld && $stable(exc_base));
endmodule

// File: tb/test_trap_status_unit.sv
`timescale 1ns/1ps
module test_trap_status_unit;
  localparam int XLEN = 64;
  localparam int TW   = 5;
  localparam int NT   = 24;

  logic            clk = 1'b0;
  logic            rst_n, cfg_has64, trap_req, sw_we_stat, sw_we_base;
  logic [TW-1:0]   trap_num;
  logic [XLEN-1:0] cur_pc, fault_addr, sw_wdata;
  logic [XLEN-1:0] redir_pc, exc_base, exc_pc, bad_addr;
  logic            redir_vld, xlen_is64, halt;
  logic [7:0]      status;

  int n_checks = 0;
  int n_fail   = 0;

  logic [XLEN-1:0] m_pc, m_base, m_epc, m_bad;
  logic [7:0]      m_stat;
  logic            m_vld, m_halt;

  always #2.5 clk = ~clk;

  trap_status_unit #(.XLEN(XLEN), .TRAP_W(TW), .NUM_TRAPS(NT), .VEC_SHIFT(7)) i_trap_status_unit (
    .clk(clk), .rst_n(rst_n), .cfg_has64(cfg_has64), .trap_req(trap_req),
    .trap_num(trap_num), .cur_pc(cur_pc), .fault_addr(fault_addr),
    .sw_we_stat(sw_we_stat), .sw_we_base(sw_we_base), .sw_wdata(sw_wdata),
    .redir_pc(redir_pc), .redir_vld(redir_vld), .status(status),
    .exc_base(exc_base), .exc_pc(exc_pc), .bad_addr(bad_addr),
    .xlen_is64(xlen_is64), .halt(halt)
  );

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_mask();
    return cfg_has64 ? 8'h1F : 8'h07;
  endfunction

  function automatic logic exp_is64(input logic [7:0] s);
    return s[1] ? s[4] : s[3];
  endfunction

  task automatic model_step();
    logic [7:0] ns;
    m_vld = 1'b0;
    if (!m_halt && trap_req) begin
      if (m_stat[0] && int'(trap_num) < NT) begin
        ns     = m_stat & 8'hF8;
        ns[1]  = 1'b1;
        ns[2]  = m_stat[1];
        m_pc   = m_base + (XLEN'(trap_num) << 7);
        m_epc  = cur_pc;
        m_bad  = fault_addr;
        m_stat = ns;
        m_vld  = 1'b1;
      end else begin
        m_halt = 1'b1;
      end
    end else if (!m_halt) begin
      if (sw_we_stat) m_stat = sw_wdata[7:0] & exp_mask();
      if (sw_we_base) m_base = sw_wdata;
    end
  endtask

  task automatic compare_all();
    check("R2",  "redir_pc",  redir_pc, m_pc);
    check("R2",  "redir_vld", XLEN'(redir_vld), XLEN'(m_vld));
    check("R3",  "exc_pc",    exc_pc, m_epc);
    check("R5",  "bad_addr",  bad_addr, m_bad);
    check("R4",  "status",    XLEN'(status), XLEN'(m_stat));
    check("R6",  "halt",      XLEN'(halt), XLEN'(m_halt));
    check("R10", "xlen_is64", XLEN'(xlen_is64), XLEN'(exp_is64(m_stat)));
    check("R12", "exc_base",  exc_base, m_base);
  endtask

  task automatic idle_inputs();
    trap_req = 0; trap_num = '0; cur_pc = '0; fault_addr = '0;
    sw_we_stat = 0; sw_we_base = 0; sw_wdata = '0;
  endtask

  task automatic cycle();
    model_step();
    @(posedge clk);
    #1;
    compare_all();
    idle_inputs();
  endtask

  task automatic do_reset(input logic has64);
    idle_inputs();
    cfg_has64 = has64;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    m_pc = '0; m_base = '0; m_epc = '0; m_bad = '0;
    m_stat = has64 ? 8'h12 : 8'h02; m_vld = 0; m_halt = 0;
    check("R1", "reset status", XLEN'(status), XLEN'(has64 ? 8'h12 : 8'h02));
    check("R1", "reset pc",     redir_pc, '0);
    check("R1", "reset base",   exc_base, '0);
    check("R1", "reset epc",    exc_pc, '0);
    check("R1", "reset bad",    bad_addr, '0);
    check("R1", "reset halt",   XLEN'(halt), '0);
  endtask

  task automatic wr_stat(input logic [7:0] v);
    sw_we_stat = 1; sw_wdata = XLEN'(v);
    cycle();
  endtask

  task automatic trap(input int n, input logic [XLEN-1:0] pc, input logic [XLEN-1:0] fa);
    trap_req = 1; trap_num = TW'(n); cur_pc = pc; fault_addr = fa;
    cycle();
  endtask

  task automatic random_phase(input logic has64, input int cycles);
    do_reset(has64);
    for (int i = 0; i < cycles; i++) begin
      if (m_halt) do_reset(has64);
      trap_req   = ($urandom % 5) == 0;
      trap_num   = TW'($urandom);
      cur_pc     = {$urandom, $urandom};
      fault_addr = {$urandom, $urandom};
      sw_we_stat = ($urandom % 3) == 0;
      sw_we_base = ($urandom % 4) == 0;
      sw_wdata   = {$urandom, $urandom};
      if (($urandom % 4) != 0) sw_wdata[0] = 1'b1;
      cycle();
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b1);

    // R9: reserved bits dropped; R10: kernel width
    wr_stat(8'hF3);
    check("R9", "status masked", XLEN'(status), XLEN'(8'h13));
    check("R10", "kernel 64", XLEN'(xlen_is64), XLEN'(1'b1));
    wr_stat(8'h09);
    check("R10", "user 64", XLEN'(xlen_is64), XLEN'(1'b1));
    wr_stat(8'h13);

    // R12 base write
    sw_we_base = 1; sw_wdata = 64'h1000;
    cycle();
    check("R12", "base", exc_base, 64'h1000);

    // R2 R3 R4 R5 trap number 3
    trap(3, 64'h40, 64'hDEAD);
    check("R2", "vector", redir_pc, 64'h1180);
    check("R3", "epc", exc_pc, 64'h40);
    check("R5", "bad", bad_addr, 64'hDEAD);
    check("R4", "mode", XLEN'(status), XLEN'(8'h16));
    cycle();
    check("R2", "pulse ends", XLEN'(redir_vld), '0);

    // R11 trap wins over base and status writes
    wr_stat(8'h13);
    trap_req = 1; trap_num = 5; cur_pc = 64'h80;
    sw_we_base = 1; sw_we_stat = 1; sw_wdata = 64'h9901;
    cycle();
    check("R11", "base kept", exc_base, 64'h1000);
    check("R11", "vector", redir_pc, 64'h1280);
    check("R11", "status from trap", XLEN'(status), XLEN'(8'h16));

    // R6 trap with enable clear
    trap(2, 64'h100, 64'h5);
    check("R6", "halt", XLEN'(halt), XLEN'(1'b1));
    check("R6", "epc kept", exc_pc, 64'h80);
    // R8 frozen
    wr_stat(8'h13);
    check("R8", "status frozen", XLEN'(status), XLEN'(8'h16));
    trap(1, 64'h200, 64'h6);
    check("R8", "halt held", XLEN'(halt), XLEN'(1'b1));
    check("R8", "no redirect", XLEN'(redir_vld), '0);

    // R7 out-of-range number
    do_reset(1'b1);
    wr_stat(8'h13);
    trap(30, 64'h300, 64'h7);
    check("R7", "halt", XLEN'(halt), XLEN'(1'b1));
    check("R7", "pc kept", redir_pc, '0);
    check("R7", "status kept", XLEN'(status), XLEN'(8'h13));

    // R9 R10 without 64-bit support
    do_reset(1'b0);
    wr_stat(8'hFF);
    check("R9", "no64 mask", XLEN'(status), XLEN'(8'h07));
    check("R10", "width 32", XLEN'(xlen_is64), '0);
    wr_stat(8'h09);
    check("R9", "user64 masked", XLEN'(status), XLEN'(8'h01));

    random_phase(1'b1, 1500);
    random_phase(1'b0, 1500);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule